// File: doc/BRIEF.md
# FPGA Byte-Stream Configuration Loader

This block loads a configuration image into a downstream FPGA over a byte-wide write port with a one-cycle write strobe and three handshake pins. The pins are an active-low program output, an active-low init input and a done input. A start pulse makes the loader pulse the program pin low and then wait for the target to release init. It then writes a fixed header and streams the payload as fixed-length frames. Each frame carries a preamble code in front and a check code behind. A trailer and startup bytes close the stream. At the end the loader raises either a success flag or an error flag.

Payload bytes come from a valid/ready byte source and are consumed strictly in order. The number of frames to send, the init-wait timeout and the minimum spacing between byte writes are inputs that stay stable during a load. Before every frame the loader samples the handshake. If the target has pulled init low, or has raised done too early, the remaining frames are skipped and the closing bytes are still written. The load then counts as failed. The handshake inputs are assumed to be synchronous to the loader clock.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After an accepted start, prog_n is low for exactly PULSE_CYCLES consecutive cycles and then returns high. No byte is written and no source byte is taken while prog_n is low.
- R2: No write strobe occurs before init_n has been seen high after the program pulse.
- R3: The first eight bytes written are FF, FF, FF, 4F, 80, AF, 9B, 4B (hex), in that order.
- R4: Each frame is written as 4F, then FRAME_BYTES (default 21) payload bytes in source order, then 4B. A payload byte is taken only on a cycle with src_valid and src_ready both high, and src_ready is never high without src_valid.
- R5: Before each frame the loader continues only while init_n is high, cfg_done is low and fewer than num_frames frames have been sent. Otherwise it skips to the closing bytes.
- R6: The last nine bytes written are 4B in second place and FF in all other places (FF, 4B, FF, FF, FF, FF, FF, FF, FF).
- R7: After the closing bytes, done_ok is set if all num_frames frames were sent and cfg_done is high; otherwise error is set. The two are never high together.
- R8: If init_n stays low for more than init_timeout cycles while waiting, error is set, no byte is written and the loader returns to idle.
- R9: wr_stb is a single-cycle pulse. Consecutive strobes are at least max(wr_gap,1) cycles apart.
- R10: busy is high from the accepted start until the result is flagged. A start while busy is ignored. done_ok and error hold until the next accepted start clears them.
- R11: After reset prog_n is high, and wr_stb, busy, done_ok and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| num_frames | input | FRM_W | Number of payload frames to send |
| init_timeout | input | TMO_W | Cycles allowed for init_n to go high |
| wr_gap | input | GAP_W | Minimum cycles between write strobes |
| src_valid | input | 1 | Payload source has a byte |
| src_data | input | 8 | Payload byte |
| src_ready | output | 1 | Loader takes the payload byte this cycle |
| prog_n | output | 1 | Active-low program/reset pin to the target |
| init_n | input | 1 | Active-low init pin from the target |
| cfg_done | input | 1 | Done pin from the target |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_data | output | 8 | Byte written with wr_stb |
| busy | output | 1 | Load in progress |
| done_ok | output | 1 | Sticky success flag |
| error | output | 1 | Sticky failure flag |

## Verification
The checker watches, on every cycle, the strobe spacing against wr_gap and the silence of the write port and the source during the program pulse. It also checks that src_ready never rises without src_valid, that the two result flags are exclusive, and that the flags are cleared when busy rises. The exact byte order of header, frames and trailer, the pulse length, the init wait and the timeout can only be shown by the bench's scenarios. The same holds for skipping frames after init drops or done rises early, and for the success and failure verdicts. The bench checks these against a target model and a payload memory.

// File: rtl/cfg_loader_pkg.sv
// Shared types and fixed byte codes for the configuration loader.
// Assumes the header and trailer lengths below are fixed by the target's
// configuration protocol and never parameterised.
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PROG, ST_WAIT, ST_HDR, ST_FCHK, ST_FRM, ST_TRL, ST_FIN
    } ld_state_e;

    localparam int HDR_LEN = 8;
    localparam int TRL_LEN = 9;
    localparam logic [7:0] CODE_PRE = 8'h4F;
    localparam logic [7:0] CODE_CHK = 8'h4B;

    // Header byte at position idx (0 is the throwaway write)
    function automatic logic [7:0] hdr_byte(input logic [3:0] idx);
        case (idx)
            4'd3:    return CODE_PRE;
            4'd4:    return 8'h80;
            4'd5:    return 8'hAF;
            4'd6:    return 8'h9B;
            4'd7:    return CODE_CHK;
            default: return 8'hFF;
        endcase
    endfunction

    // Trailer/startup byte at position idx
    function automatic logic [7:0] trl_byte(input logic [3:0] idx);
        return (idx == 4'd1) ? CODE_CHK : 8'hFF;
    endfunction

endpackage

// File: rtl/cfg_gap_pacer.sv
// Write pacer: after each fire it holds ready low so that the next fire is
// at least max(gap,1) cycles later. Assumes gap is stable during a load.
module cfg_gap_pacer #(
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [GAP_W-1:0] gap,
    output logic             ready
);
    logic [GAP_W-1:0] cnt;

    assign ready = (cnt == '0);

    // Reload on a write, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (fire)
            cnt <= (gap == '0) ? '0 : gap - 1'b1;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/cfg_down_timer.sv
// Loadable down-counter shared by the program pulse and the init timeout.
// zero is high once the loaded count has run out.
module cfg_down_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    assign zero = (cnt == '0);

    // Load takes priority; otherwise decrement until zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (!zero)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/cfg_seq_fsm.sv
// Load sequencer: program pulse, init wait, header, framed payload with a
// handshake check before each frame, closing bytes and verdict.
// Assumes init_n and cfg_done are already synchronous to clk.
module cfg_seq_fsm
    import cfg_loader_pkg::*;
#(
    parameter int FRM_W        = 16,
    parameter int TMO_W        = 16,
    parameter int TMR_W        = 16,
    parameter int PULSE_CYCLES = 25,
    parameter int FRAME_BYTES  = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [FRM_W-1:0] num_frames,
    input  logic [TMO_W-1:0] init_timeout,
    input  logic             src_valid,
    input  logic [7:0]       src_data,
    input  logic             init_n,
    input  logic             cfg_done,
    input  logic             pace_rdy,
    input  logic             tmr_zero,
    output logic             fire,
    output logic             tmr_load,
    output logic [TMR_W-1:0] tmr_val,
    output logic             src_ready,
    output logic             prog_n,
    output logic             wr_stb,
    output logic [7:0]       wr_data,
    output logic             busy,
    output logic             done_ok,
    output logic             error
);
    localparam int IDX_MAX  = (FRAME_BYTES + 1 > HDR_LEN) ? FRAME_BYTES + 1 : HDR_LEN;
    localparam int IDX_W    = $clog2(IDX_MAX + 1);
    localparam int FRM_LAST = FRAME_BYTES + 1;

    ld_state_e        state, state_nxt;
    logic [IDX_W-1:0] idx, idx_nxt;
    logic [FRM_W-1:0] sent;
    logic             sent_inc;
    logic [7:0]       byte_sel;
    logic             set_ok, set_err;

    assign prog_n = (state != ST_PROG);
    assign busy   = (state != ST_IDLE);

    // Next state, byte selection and write/timer requests
    always_comb begin
        state_nxt = state;
        idx_nxt   = idx;
        fire      = 1'b0;
        byte_sel  = 8'hFF;
        src_ready = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        sent_inc  = 1'b0;
        set_ok    = 1'b0;
        set_err   = 1'b0;
        case (state)
            ST_IDLE: if (start) begin
                state_nxt = ST_PROG;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(PULSE_CYCLES - 1);
            end
            ST_PROG: if (tmr_zero) begin
                state_nxt = ST_WAIT;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(init_timeout);
            end
            ST_WAIT: begin
                idx_nxt = '0;
                if (init_n)
                    state_nxt = ST_HDR;
                else if (tmr_zero) begin
                    state_nxt = ST_IDLE;
                    set_err   = 1'b1;
                end
            end
            ST_HDR: begin
                byte_sel = hdr_byte(idx[3:0]);
                fire     = pace_rdy;
                if (fire) begin
                    if (idx == IDX_W'(HDR_LEN - 1)) begin
                        state_nxt = ST_FCHK;
                        idx_nxt   = '0;
                    end else
                        idx_nxt = idx + 1'b1;
                end
            end
            ST_FCHK: begin
                idx_nxt = '0;
                if (init_n && !cfg_done && (sent != num_frames))
                    state_nxt = ST_FRM;
                else
                    state_nxt = ST_TRL;
            end
            ST_FRM: begin
                if (idx == '0) begin
                    byte_sel = CODE_PRE;
                    fire     = pace_rdy;
                end else if (idx == IDX_W'(FRM_LAST)) begin
                    byte_sel = CODE_CHK;
                    fire     = pace_rdy;
                end else begin
                    byte_sel  = src_data;
                    fire      = pace_rdy && src_valid;
                    src_ready = fire;
                end
                if (fire) begin
                    if (idx == IDX_W'(FRM_LAST)) begin
                        state_nxt = ST_FCHK;
                        sent_inc  = 1'b1;
                        idx_nxt   = '0;
                    end else
                        idx_nxt = idx + 1'b1;
                end
            end
            ST_TRL: begin
                byte_sel = trl_byte(idx[3:0]);
                fire     = pace_rdy;
                if (fire) begin
                    if (idx == IDX_W'(TRL_LEN - 1))
                        state_nxt = ST_FIN;
                    else
                        idx_nxt = idx + 1'b1;
                end
            end
            ST_FIN: begin
                state_nxt = ST_IDLE;
                if ((sent == num_frames) && cfg_done)
                    set_ok = 1'b1;
                else
                    set_err = 1'b1;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State, byte index and frame counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            sent  <= '0;
        end else begin
            state <= state_nxt;
            idx   <= idx_nxt;
            if (state == ST_IDLE && start)
                sent <= '0;
            else if (sent_inc)
                sent <= sent + 1'b1;
        end
    end

    // Registered write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_data <= 8'h00;
        end else begin
            wr_stb <= fire;
            if (fire)
                wr_data <= byte_sel;
        end
    end

    // Sticky verdict flags, cleared by an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_ok <= 1'b0;
            error   <= 1'b0;
        end else if (state == ST_IDLE && start) begin
            done_ok <= 1'b0;
            error   <= 1'b0;
        end else begin
            if (set_ok)  done_ok <= 1'b1;
            if (set_err) error   <= 1'b1;
        end
    end
endmodule

// File: rtl/fpga_cfg_loader.sv
// Top of the configuration loader: ties the sequencer to the write pacer
// and the shared down-timer. Assumes num_frames, init_timeout and wr_gap
// are held stable while busy.
module fpga_cfg_loader #(
    parameter int FRM_W        = 16,
    parameter int TMO_W        = 16,
    parameter int GAP_W        = 4,
    parameter int PULSE_CYCLES = 25,
    parameter int FRAME_BYTES  = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [FRM_W-1:0] num_frames,
    input  logic [TMO_W-1:0] init_timeout,
    input  logic [GAP_W-1:0] wr_gap,
    input  logic             src_valid,
    input  logic [7:0]       src_data,
    output logic             src_ready,
    output logic             prog_n,
    input  logic             init_n,
    input  logic             cfg_done,
    output logic             wr_stb,
    output logic [7:0]       wr_data,
    output logic             busy,
    output logic             done_ok,
    output logic             error
);
    localparam int PW    = $clog2(PULSE_CYCLES + 1);
    localparam int TMR_W = (TMO_W > PW) ? TMO_W : PW;

    logic             fire, pace_rdy, tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;

    cfg_gap_pacer #(.GAP_W(GAP_W)) u_pacer (
        .clk(clk), .rst_n(rst_n), .fire(fire), .gap(wr_gap), .ready(pace_rdy)
    );

    cfg_down_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    cfg_seq_fsm #(
        .FRM_W(FRM_W), .TMO_W(TMO_W), .TMR_W(TMR_W),
        .PULSE_CYCLES(PULSE_CYCLES), .FRAME_BYTES(FRAME_BYTES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .num_frames(num_frames),
        .init_timeout(init_timeout), .src_valid(src_valid), .src_data(src_data),
        .init_n(init_n), .cfg_done(cfg_done), .pace_rdy(pace_rdy), .tmr_zero(tmr_zero),
        .fire(fire), .tmr_load(tmr_load), .tmr_val(tmr_val), .src_ready(src_ready),
        .prog_n(prog_n), .wr_stb(wr_stb), .wr_data(wr_data), .busy(busy),
        .done_ok(done_ok), .error(error)
    );
endmodule

// File: rtl/cfg_loader_chk.sv
// Checker for the configuration loader, attached by bind. Measures the
// distance between write strobes with its own counter.
module cfg_loader_chk #(
    parameter int GAP_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [GAP_W-1:0] wr_gap,
    input logic             src_valid,
    input logic             src_ready,
    input logic             prog_n,
    input logic             wr_stb,
    input logic             busy,
    input logic             done_ok,
    input logic             error
);
    logic [GAP_W:0] since;
    logic           seen;
    logic [GAP_W:0] gmin;

    assign gmin = (wr_gap == '0) ? (GAP_W+1)'(1) : {1'b0, wr_gap};

    // Cycles since the last strobe, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since <= '0;
            seen  <= 1'b0;
        end else if (wr_stb) begin
            since <= (GAP_W+1)'(1);
            seen  <= 1'b1;
        end else if (since != '1)
            since <= since + 1'b1;
    end

    p_strobe_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && seen) |-> (since >= gmin));

    p_quiet_in_prog_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> (!wr_stb && !src_ready));

    p_ready_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> src_valid);

    p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_ok && error));

    p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!done_ok && !error));

    p_idle_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !wr_stb);
endmodule

bind fpga_cfg_loader cfg_loader_chk #(.GAP_W(GAP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_gap(wr_gap), .src_valid(src_valid),
    .src_ready(src_ready), .prog_n(prog_n), .wr_stb(wr_stb), .busy(busy),
    .done_ok(done_ok), .error(error)
);

// File: tb/sim_fpga_cfg_loader.sv
`timescale 1ns/1ps
module sim_fpga_cfg_loader;
    localparam int FRM_W = 16, TMO_W = 16, GAP_W = 4, PULSE = 25, FB = 21;
    localparam int FLEN = FB + 2;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [FRM_W-1:0] num_frames = '0;
    logic [TMO_W-1:0] init_timeout = '0;
    logic [GAP_W-1:0] wr_gap = '0;
    logic src_valid = 1'b0, src_ready, prog_n, init_n = 1'b1, cfg_done = 1'b0;
    logic [7:0] src_data = 8'h00, wr_data;
    logic wr_stb, busy, done_ok, error;

    always #10 clk = ~clk;

    fpga_cfg_loader #(.FRM_W(FRM_W), .TMO_W(TMO_W), .GAP_W(GAP_W),
                      .PULSE_CYCLES(PULSE), .FRAME_BYTES(FB)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .num_frames(num_frames),
        .init_timeout(init_timeout), .wr_gap(wr_gap), .src_valid(src_valid),
        .src_data(src_data), .src_ready(src_ready), .prog_n(prog_n),
        .init_n(init_n), .cfg_done(cfg_done), .wr_stb(wr_stb), .wr_data(wr_data),
        .busy(busy), .done_ok(done_ok), .error(error)
    );

    int n_tests = 0, n_fail = 0;
    int cyc = 0;
    logic [7:0] mem [0:127];
    logic [7:0] log_b [0:255];
    int log_n, first_stb, last_stb, min_gap, low_cnt, pulses, first_init_hi;
    int ptr, init_ctr, idel, akind, ak, exp_total;
    bit init_hold, abort_init, done_force, done_end, rdone, xfer, prev_prog;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_hdr(input int i);
        case (i)
            3: return 'h4F; 4: return 'h80; 5: return 'hAF; 6: return 'h9B; 7: return 'h4B;
            default: return 'hFF;
        endcase
    endfunction

    function automatic int exp_trl(input int i);
        return (i == 1) ? 'h4B : 'hFF;
    endfunction

    function automatic int exp_frm(input int f, input int j);
        if (j == 0) return 'h4F;
        if (j == FLEN - 1) return 'h4B;
        return int'(mem[(f * FB + j - 1) % 128]);
    endfunction

    // Observer and target model, sampled away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (wr_stb) begin
                log_b[log_n % 256] = wr_data;
                if (last_stb >= 0 && cyc - last_stb < min_gap) min_gap = cyc - last_stb;
                if (first_stb < 0) first_stb = cyc;
                last_stb = cyc;
                log_n++;
                if (akind == 1 && log_n == 8 + FLEN * ak + 1) abort_init = 1;
                if (akind == 2 && log_n == 8 + FLEN * ak + 1) done_force = 1;
                if (rdone && log_n == exp_total - 3) done_end = 1;
            end
            if (!prog_n) begin
                low_cnt++;
                if (prev_prog) pulses++;
                init_hold = 1;
                init_ctr = idel;
            end else if (init_hold) begin
                if (init_ctr == 0) init_hold = 0; else init_ctr--;
            end
            if (init_n && prog_n && pulses > 0 && first_init_hi < 0) first_init_hi = cyc;
            if (src_valid && src_ready) xfer = 1;
        end
        prev_prog = prog_n;
        if (cyc > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Input driver, just after the active edge
    always @(posedge clk) begin
        #1;
        if (xfer) begin ptr++; xfer = 0; end
        src_valid = ($urandom % 4) != 0;
        src_data  = mem[ptr % 128];
        init_n    = !(init_hold || abort_init);
        cfg_done  = done_force || done_end;
    end

    task automatic pulse_start();
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
    endtask

    // One load; exp_to: expect timeout; mid: extra start while busy
    task automatic run_case(input int nfr, input int gap, input int idl, input int tmo,
                            input int kind, input int kfr, input bit rd,
                            input bit exp_to, input bit mid);
        int ef, wait_c, bad;
        bit exp_ok;
        @(negedge clk);
        num_frames = FRM_W'(nfr); wr_gap = GAP_W'(gap); init_timeout = TMO_W'(tmo);
        for (int i = 0; i < 128; i++) mem[i] = 8'($urandom);
        log_n = 0; first_stb = -1; last_stb = -1; min_gap = 1000; low_cnt = 0;
        pulses = 0; first_init_hi = -1; ptr = 0; idel = idl; akind = kind; ak = kfr;
        abort_init = 0; done_force = 0; done_end = 0; rdone = rd;
        ef = (kind != 0 && kfr + 1 < nfr) ? kfr + 1 : nfr;
        exp_total = 8 + FLEN * ef + 9;
        exp_ok = !exp_to && (ef == nfr) && rd && (kind != 2 || kfr + 1 >= nfr);
        pulse_start();
        @(negedge clk);
        chk(busy && !done_ok && !error, "R10 busy and flags cleared after start",
            {busy, done_ok, error}, 3'b100);
        wait_c = 0;
        while (!(done_ok || error) && wait_c < 20000) begin
            @(negedge clk); wait_c++;
            if (mid && wait_c == 60) pulse_start();
        end
        chk(pulses == 1 && low_cnt == PULSE, "R1 program pulse length", low_cnt, PULSE);
        if (exp_to) begin
            chk(log_n == 0, "R8 no writes on timeout", log_n, 0);
            chk(error && !done_ok && !busy, "R8 timeout flags error", error, 1);
        end else begin
            chk(first_stb > first_init_hi && first_init_hi > 0, "R2 first write after init high",
                first_stb, first_init_hi + 1);
            chk(log_n == exp_total, "R5 byte count", log_n, exp_total);
            bad = 0;
            for (int i = 0; i < 8; i++) if (int'(log_b[i]) != exp_hdr(i)) bad++;
            chk(bad == 0, "R3 header bytes", bad, 0);
            bad = 0;
            for (int f = 0; f < ef; f++)
                for (int j = 0; j < FLEN; j++)
                    if (int'(log_b[8 + f * FLEN + j]) != exp_frm(f, j)) bad++;
            chk(bad == 0, "R4 frame bytes", bad, 0);
            bad = 0;
            for (int i = 0; i < 9; i++)
                if (int'(log_b[(exp_total - 9 + i) % 256]) != exp_trl(i)) bad++;
            chk(bad == 0, "R6 closing bytes", bad, 0);
            chk(min_gap >= ((gap == 0) ? 1 : gap), "R9 strobe spacing", min_gap, gap);
            chk(done_ok == exp_ok && error == !exp_ok, "R7 verdict", done_ok, exp_ok);
        end
        repeat (6) @(negedge clk);
        chk(!busy && (done_ok || error) && !(done_ok && error), "R10 flags sticky",
            {done_ok, error}, exp_ok ? 2 : 1);
        abort_init = 0; done_force = 0; done_end = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        prev_prog = 1; xfer = 0; akind = 0; rdone = 0; idel = 0;
        init_hold = 0; abort_init = 0; done_force = 0; done_end = 0; log_n = 0;
        repeat (3) @(negedge clk);
        chk(prog_n && !wr_stb && !busy && !done_ok && !error, "R11 reset state",
            {prog_n, wr_stb, busy, done_ok, error}, 5'b10000);
        rst_n = 1'b1;
        // directed cases
        run_case(3, 1, 5, 200, 0, 0, 1, 0, 0);   // R4 nominal
        run_case(2, 4, 12, 200, 0, 0, 1, 0, 1);  // R9 gap, R10 start while busy
        run_case(0, 0, 0, 200, 0, 0, 1, 0, 0);   // R5 zero frames
        run_case(3, 2, 3, 200, 1, 0, 0, 0, 0);   // R5 abort on init low
        run_case(4, 1, 3, 200, 2, 1, 0, 0, 0);   // R5 abort on early done
        run_case(1, 1, 3, 200, 0, 0, 0, 0, 0);   // R7 done never raised
        run_case(2, 1, 40, 10, 0, 0, 1, 1, 0);   // R8 timeout
        // random mix
        for (int k = 0; k < 6; k++)
            run_case(int'($urandom % 5), int'($urandom % 6), int'($urandom % 16), 200,
                     0, 0, 1, 0, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule